// File: doc/BRIEF.md
# Serial Asynchronous Transmitter with Break and Flow Control

This block is the transmit half of an asynchronous serial channel. A host writes a character into a one-entry holding register. The character then moves into a shift register and goes out on the serial line as a framed character. The frame is a start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity or address bit, then a stop interval. The stop interval is programmable in sixteenths of a bit. Every change of the line is paced by a bit-clock enable pulse (`tick`). That pulse stands for either a 16x oversampling clock or a 1x bit clock. An external clock edge detector that makes the pulse from a falling clock edge sits outside this block.

Around the core shifter the block provides four controls. It can hold the line at space (a break). It can gate the start of each character on an active-low clear-to-send input. It can drive an active-low request-to-send that drops on its own once the last character has left. In multidrop use, the extra bit after the data can be forced to a programmable address/data marker. Baud-rate generation and bus decoding are handled by the neighbouring logic.

Top module: `utx_core`

## Requirements
- R1: After reset the line `txd` is 1, `tx_rdy` and `tx_empty` are 0, `rts_n` is 1, and the transmitter is disabled.
- R2: A character is sent as start bit 0, then data LSB first, then the stop interval at 1. `txd` changes only in cycles where `tick` is 1. Each start, data and parity bit lasts 16 ticks when `cfg_x1`=0 and 1 tick when `cfg_x1`=1.
- R3: `cfg_dbits` selects the data width: 0=5, 1=6, 2=7, 3=8 bits. Bits above the width are not sent.
- R4: `cfg_par` selects the extra bit: 0 none; 1 even (data bits plus extra bit hold an even number of ones); 2 odd; 3 forced to `cfg_extra_bit`, where 1 marks an address character in multidrop use.
- R5: `cfg_stop` gives the stop length in sixteenths of a bit. It is clamped to 16..32, so 24 gives 1.5 bits. In 1x mode the stop lasts ceil(clamped/16) ticks.
- R6: `tx_rdy` is 1 while the block is enabled and the holding register is empty. An accepted write clears it. A write while `tx_rdy` is 0 is ignored. `tx_empty` is 1 only when enabled with both the holding register and the shifter empty.
- R7: A character waiting in the holding register starts on the tick that ends the previous stop interval, so no idle gap appears.
- R8: A break-start command (only while enabled) holds `txd` at 0 once the shifter is idle, until a break-stop command. Writes accepted during the break are discarded and never sent.
- R9: With `cfg_cts_gate`=1 a character starts only while `cts_n` is 0. A held character waits, with the line at mark, until then.
- R10: `cmd_rts_set` drives `rts_n` to 0. With `cfg_rts_auto`=1, `rts_n` returns to 1 when the stop interval of the last character ends with no character waiting. With `cfg_rts_auto`=0 it stays 0.
- R11: `cmd_enable`/`cmd_disable` switch the transmitter; disable wins when both are given together. While disabled, writes are ignored and `tx_rdy` is 0. A character already accepted is still sent in full.
- R12: When idle and not in break, `txd` rests at mark (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-clock enable (16x or 1x) |
| cfg_x1 | input | 1 | 1: tick is a 1x bit clock; 0: 16x |
| cfg_dbits | input | 2 | Data width select (5..8 bits) |
| cfg_par | input | 2 | Extra-bit mode: none/even/odd/forced |
| cfg_extra_bit | input | 1 | Forced extra-bit value (1 = address) |
| cfg_stop | input | $clog2(3*OVS) | Stop length in 1/OVS bit units |
| cfg_cts_gate | input | 1 | Gate character start on clear-to-send |
| cfg_rts_auto | input | 1 | Release request-to-send when done |
| cts_n | input | 1 | Clear-to-send, active low |
| cmd_enable | input | 1 | Enable pulse |
| cmd_disable | input | 1 | Disable pulse |
| cmd_brk_on | input | 1 | Start-break pulse |
| cmd_brk_off | input | 1 | Stop-break pulse |
| cmd_rts_set | input | 1 | Assert request-to-send pulse |
| wr_stb | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shifter both empty |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The hardest case to reach from the ports is the exact length of a fractional stop interval. On a lone character, the stop merges into the idle mark that follows, so its end cannot be seen. The stimulus therefore writes a second character as soon as `tx_rdy` returns after the first one loads. The next start edge then marks the precise end of the stop. The bench compares the whole line waveform, cycle by cycle, against one built from the requirements. It does this for the clamped, 1.5-bit and 2-bit stop settings, in 1x mode, and with a tick that fires only every third cycle.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [2:0] {
        UTX_IDLE  = 3'd0,
        UTX_START = 3'd1,
        UTX_DATA  = 3'd2,
        UTX_XBIT  = 3'd3,
        UTX_STOP  = 3'd4
    } utx_phase_e;

    typedef enum logic [1:0] {
        UTX_PAR_NONE  = 2'd0,
        UTX_PAR_EVEN  = 2'd1,
        UTX_PAR_ODD   = 2'd2,
        UTX_PAR_FORCE = 2'd3
    } utx_par_e;

endpackage

// File: rtl/utx_xbit_gen.sv
module utx_xbit_gen #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    dbits_i,
    input  logic [1:0]    mode_i,
    input  logic          forced_i,
    output logic          xbit_o
);
    import utx_pkg::*;

    localparam int MIN_BITS = DW - 3;

    logic [DW-1:0] live;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign live[i] = data_i[i] & (i < (MIN_BITS + int'(dbits_i)));
    end

    always_comb begin
        unique case (utx_par_e'(mode_i))
            UTX_PAR_EVEN:  xbit_o = ^live;
            UTX_PAR_ODD:   xbit_o = ~(^live);
            UTX_PAR_FORCE: xbit_o = forced_i;
            default:       xbit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/utx_subbit_timer.sv
module utx_subbit_timer #(
    parameter  int OVS   = 16,
    localparam int CNT_W = $clog2(3 * OVS)
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             x1_i,
    input  logic             in_stop_i,
    input  logic [CNT_W-1:0] stop_cfg_i,
    output logic [CNT_W-1:0] nxt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE_BIT = CNT_W'(OVS);
    localparam logic [CNT_W-1:0] TWO_BIT = CNT_W'(2 * OVS);

    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] stop_lim;
    logic [CNT_W-1:0] lim;

    always_comb begin
        step = x1_i ? ONE_BIT : CNT_W'(1);
        if (stop_cfg_i < ONE_BIT)      stop_lim = ONE_BIT;
        else if (stop_cfg_i > TWO_BIT) stop_lim = TWO_BIT;
        else                           stop_lim = stop_cfg_i;
        lim    = in_stop_i ? stop_lim : ONE_BIT;
        nxt_o  = cnt_i + step;
        done_o = (nxt_o >= lim);
    end

endmodule

// File: rtl/utx_core.sv
module utx_core #(
    parameter  int OVS   = 16,
    localparam int CNT_W = $clog2(3 * OVS),
    localparam int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_x1,
    input  logic [1:0]       cfg_dbits,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_extra_bit,
    input  logic [CNT_W-1:0] cfg_stop,
    input  logic             cfg_cts_gate,
    input  logic             cfg_rts_auto,
    input  logic             cts_n,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    input  logic             cmd_brk_on,
    input  logic             cmd_brk_off,
    input  logic             cmd_rts_set,
    input  logic             wr_stb,
    input  logic [DW-1:0]    wr_data,
    output logic             txd,
    output logic             tx_rdy,
    output logic             tx_empty,
    output logic             rts_n
);
    import utx_pkg::*;

    localparam int LEFT_W = $clog2(DW);

    typedef struct packed {
        logic              en;
        logic              brk;
        logic              rts;
        logic              hold_full;
        logic [DW-1:0]     hold;
        utx_phase_e        phase;
        logic [DW-1:0]     shreg;
        logic [LEFT_W-1:0] bits_left;
        logic              has_x;
        logic              xbit;
        logic [CNT_W-1:0]  cnt;
        logic              txd;
    } utx_state_t;

    utx_state_t s_d, s_q;

    logic             wr_ok_d;
    logic             load_ok_d;
    logic             start_d;
    logic             xbit_calc;
    logic [CNT_W-1:0] t_nxt;
    logic             t_done;

    utx_xbit_gen #(.DW(DW)) u_xbit (
        .data_i   (s_q.hold),
        .dbits_i  (cfg_dbits),
        .mode_i   (cfg_par),
        .forced_i (cfg_extra_bit),
        .xbit_o   (xbit_calc)
    );

    utx_subbit_timer #(.OVS(OVS)) u_timer (
        .cnt_i      (s_q.cnt),
        .x1_i       (cfg_x1),
        .in_stop_i  (s_q.phase == UTX_STOP),
        .stop_cfg_i (cfg_stop),
        .nxt_o      (t_nxt),
        .done_o     (t_done)
    );

    always_comb begin
        s_d       = s_q;
        wr_ok_d   = wr_stb & s_q.en & ~s_q.hold_full & ~s_q.brk;
        load_ok_d = s_q.hold_full & ~s_q.brk & (~cfg_cts_gate | ~cts_n);
        start_d   = 1'b0;

        if (cmd_enable)             s_d.en  = 1'b1;
        if (cmd_disable)            s_d.en  = 1'b0;
        if (cmd_brk_on && s_q.en)   s_d.brk = 1'b1;
        if (cmd_brk_off)            s_d.brk = 1'b0;

        if (wr_ok_d) begin
            s_d.hold      = wr_data;
            s_d.hold_full = 1'b1;
        end

        if (tick) begin
            if (s_q.phase == UTX_IDLE) begin
                if (load_ok_d) start_d = 1'b1;
                else           s_d.txd = ~s_q.brk;
            end else begin
                s_d.cnt = t_done ? '0 : t_nxt;
                if (t_done) begin
                    unique case (s_q.phase)
                        UTX_START: begin
                            s_d.phase = UTX_DATA;
                            s_d.txd   = s_q.shreg[0];
                            s_d.shreg = s_q.shreg >> 1;
                        end
                        UTX_DATA: begin
                            if (s_q.bits_left != '0) begin
                                s_d.txd       = s_q.shreg[0];
                                s_d.shreg     = s_q.shreg >> 1;
                                s_d.bits_left = s_q.bits_left - 1'b1;
                            end else if (s_q.has_x) begin
                                s_d.phase = UTX_XBIT;
                                s_d.txd   = s_q.xbit;
                            end else begin
                                s_d.phase = UTX_STOP;
                                s_d.txd   = 1'b1;
                            end
                        end
                        UTX_XBIT: begin
                            s_d.phase = UTX_STOP;
                            s_d.txd   = 1'b1;
                        end
                        default: begin
                            if (load_ok_d) begin
                                start_d = 1'b1;
                            end else begin
                                s_d.phase = UTX_IDLE;
                                s_d.txd   = 1'b1;
                                if (cfg_rts_auto && !s_q.hold_full && !wr_ok_d)
                                    s_d.rts = 1'b0;
                            end
                        end
                    endcase
                end
            end
        end

        if (start_d) begin
            s_d.phase     = UTX_START;
            s_d.txd       = 1'b0;
            s_d.shreg     = s_q.hold;
            s_d.hold_full = 1'b0;
            s_d.xbit      = xbit_calc;
            s_d.has_x     = (utx_par_e'(cfg_par) != UTX_PAR_NONE);
            s_d.bits_left = LEFT_W'(DW - 4) + LEFT_W'(cfg_dbits);
            s_d.cnt       = '0;
        end

        if (cmd_rts_set) s_d.rts = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= UTX_IDLE;
            s_q.txd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd      = s_q.txd;
    assign tx_rdy   = s_q.en & ~s_q.hold_full;
    assign tx_empty = tx_rdy & (s_q.phase == UTX_IDLE);
    assign rts_n    = ~s_q.rts;

    // R2: the line moves only on a bit-clock enable
    p_txd_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    // R2: entering the start bit always drives space
    p_start_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == UTX_START && $past(s_q.phase) != UTX_START) |-> !txd);

    // R6: an accepted write takes the holding register
    p_wr_clears_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_rdy && !s_q.brk) |=> !tx_rdy);

    // R6: empty implies ready
    p_empty_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    // R8: an idle break keeps the line at space
    p_break_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.brk && $past(s_q.brk) && $past(tick) && $past(s_q.phase == UTX_IDLE)) |-> !txd);

    // R8: no character starts while a break is in force
    p_break_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.brk && s_q.phase == UTX_IDLE) |=> s_q.phase == UTX_IDLE);

    // R9: a blocked clear-to-send keeps the shifter idle
    p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_gate && cts_n && s_q.phase == UTX_IDLE) |=> s_q.phase == UTX_IDLE);

    // R10: request-to-send is only released by the automatic path
    p_rts_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> $past(cfg_rts_auto));

endmodule

// File: tb/utx_core_tb_top.sv
module utx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_x1 = 1'b0;
    logic [1:0] cfg_dbits = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_extra_bit = 1'b0;
    logic [5:0] cfg_stop = 6'd16;
    logic       cfg_cts_gate = 1'b0;
    logic       cfg_rts_auto = 1'b0;
    logic       cts_n = 1'b1;
    logic       cmd_enable = 1'b0;
    logic       cmd_disable = 1'b0;
    logic       cmd_brk_on = 1'b0;
    logic       cmd_brk_off = 1'b0;
    logic       cmd_rts_set = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_rdy, tx_empty, rts_n;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_div = 1;
    int tcnt = 0;

    logic exp_w [0:4095];
    int   exp_len = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (tcnt >= tick_div - 1) begin
            tcnt <= 0;
            tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick <= 1'b0;
        end
    end

    utx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_x1(cfg_x1),
        .cfg_dbits(cfg_dbits), .cfg_par(cfg_par), .cfg_extra_bit(cfg_extra_bit),
        .cfg_stop(cfg_stop), .cfg_cts_gate(cfg_cts_gate), .cfg_rts_auto(cfg_rts_auto),
        .cts_n(cts_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off), .cmd_rts_set(cmd_rts_set),
        .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd), .tx_rdy(tx_rdy),
        .tx_empty(tx_empty), .rts_n(rts_n)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmd(int which);
        @(negedge clk);
        case (which)
            0: cmd_enable  = 1'b1;
            1: cmd_disable = 1'b1;
            2: cmd_brk_on  = 1'b1;
            3: cmd_brk_off = 1'b1;
            default: cmd_rts_set = 1'b1;
        endcase
        @(negedge clk);
        {cmd_enable, cmd_disable, cmd_brk_on, cmd_brk_off, cmd_rts_set} = '0;
    endtask

    task automatic write_byte(logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic push(logic v, int n);
        for (int i = 0; i < n; i++) begin
            exp_w[exp_len] = v;
            exp_len++;
        end
    endtask

    task automatic push_frame(logic [7:0] d);
        int  bt = cfg_x1 ? 1 : 16;
        int  nb = int'(cfg_dbits) + 5;
        int  sv = int'(cfg_stop);
        int  sl = sv < 16 ? 16 : (sv > 32 ? 32 : sv);
        int  st = cfg_x1 ? (sl + 15) / 16 : sl;
        logic p = 1'b0;
        push(1'b0, bt * tick_div);
        for (int i = 0; i < nb; i++) begin
            push(d[i], bt * tick_div);
            p = p ^ d[i];
        end
        if (cfg_par == 2'd1)      push(p, bt * tick_div);
        else if (cfg_par == 2'd2) push(~p, bt * tick_div);
        else if (cfg_par == 2'd3) push(cfg_extra_bit, bt * tick_div);
        push(1'b1, st * tick_div);
    endtask

    task automatic capture(string req, string what);
        int wait_c = 0;
        int bad = -1;
        logic act = 1'b0;
        while (txd !== 1'b0 && wait_c < 5000) begin
            @(negedge clk);
            wait_c++;
        end
        for (int i = 0; i < exp_len; i++) begin
            if (bad < 0 && txd !== exp_w[i]) begin
                bad = i;
                act = txd;
            end
            @(negedge clk);
        end
        if (bad < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, $sformatf("%s sample %0d", what, bad), int'(act), int'(exp_w[bad]));
    endtask

    task automatic send_one(logic [7:0] d, string req, string what);
        exp_len = 0;
        push_frame(d);
        push(1'b1, 8 * tick_div);
        fork
            capture(req, what);
            write_byte(d);
        join
    endtask

    task automatic send_two(logic [7:0] a, logic [7:0] b, string req, string what);
        exp_len = 0;
        push_frame(a);
        push_frame(b);
        push(1'b1, 4 * tick_div);
        fork
            capture(req, what);
            begin
                write_byte(a);
                while (!tx_rdy) @(negedge clk);
                write_byte(b);
            end
        join
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_rdy === 1'b0, "R1", "tx_rdy after reset", int'(tx_rdy), 0);
        chk(tx_empty === 1'b0, "R1", "tx_empty after reset", int'(tx_empty), 0);
        chk(rts_n === 1'b1, "R1", "rts_n after reset", int'(rts_n), 1);
    endtask

    task automatic t_disabled_write();
        int lows = 0;
        write_byte(8'h00);
        for (int i = 0; i < 100; i++) begin
            if (txd !== 1'b1) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R11", "write while disabled sent nothing", lows, 0);
        chk(tx_rdy === 1'b0, "R11", "tx_rdy while disabled", int'(tx_rdy), 0);
    endtask

    task automatic t_basic();
        cmd(0);
        chk(tx_rdy === 1'b1, "R6", "tx_rdy after enable", int'(tx_rdy), 1);
        chk(tx_empty === 1'b1, "R6", "tx_empty after enable", int'(tx_empty), 1);
        cfg_dbits = 2'd3; cfg_par = 2'd0; cfg_stop = 6'd16;
        exp_len = 0;
        push_frame(8'hA5);
        push(1'b1, 8);
        fork
            capture("R2", "8N1 0xA5 waveform");
            begin
                write_byte(8'hA5);
                chk(tx_rdy === 1'b0, "R6", "tx_rdy after write", int'(tx_rdy), 0);
                wr_stb = 1'b1; wr_data = 8'h00;
                @(negedge clk);
                wr_stb = 1'b0;
                repeat (40) @(negedge clk);
                chk(tx_rdy === 1'b1 && tx_empty === 1'b0, "R6", "mid-frame rdy/empty",
                    int'({tx_rdy, tx_empty}), 2);
            end
        join
        chk(tx_empty === 1'b1, "R6", "tx_empty after frame", int'(tx_empty), 1);
        chk(txd === 1'b1, "R12", "idle mark after frame", int'(txd), 1);
        repeat (150) @(negedge clk);
        chk(txd === 1'b1, "R6", "write while full not sent", int'(txd), 1);
    endtask

    task automatic t_formats();
        cfg_stop = 6'd16;
        cfg_dbits = 2'd0; cfg_par = 2'd1;
        send_one(8'hF3, "R3", "5 bits even parity");
        cfg_dbits = 2'd2; cfg_par = 2'd2;
        send_one(8'hDA, "R4", "7 bits odd parity");
        cfg_dbits = 2'd1; cfg_par = 2'd3; cfg_extra_bit = 1'b1;
        send_one(8'h2C, "R4", "6 bits forced address bit 1");
        cfg_dbits = 2'd3; cfg_par = 2'd3; cfg_extra_bit = 1'b0;
        send_one(8'hFF, "R4", "8 bits forced data bit 0");
        cfg_dbits = 2'd3; cfg_par = 2'd1;
        send_one(8'h6E, "R4", "8 bits even parity");
        cfg_par = 2'd0;
    endtask

    task automatic t_stop();
        cfg_dbits = 2'd3; cfg_par = 2'd0;
        cfg_stop = 6'd24; send_two(8'h81, 8'h7E, "R5", "1.5 stop back to back");
        cfg_stop = 6'd32; send_two(8'h0F, 8'hF0, "R5", "2 stop back to back");
        cfg_stop = 6'd8;  send_two(8'h33, 8'hCC, "R5", "stop clamped up to 16");
        cfg_stop = 6'd40; send_two(8'h55, 8'hAA, "R7", "stop clamped down to 32");
        cfg_stop = 6'd20; send_two(8'h01, 8'h80, "R7", "20/16 stop back to back");
    endtask

    task automatic t_x1();
        cfg_x1 = 1'b1; cfg_dbits = 2'd3; cfg_par = 2'd1;
        cfg_stop = 6'd24; send_two(8'h96, 8'h69, "R5", "1x mode stop 1.5 rounds to 2");
        cfg_stop = 6'd16; send_two(8'hC3, 8'h3C, "R2", "1x mode one tick per bit");
        cfg_x1 = 1'b0; cfg_par = 2'd0; cfg_stop = 6'd16;
    endtask

    task automatic t_tickdiv();
        tick_div = 3;
        repeat (6) @(negedge clk);
        cfg_dbits = 2'd2; cfg_par = 2'd1;
        send_one(8'h4D, "R2", "tick every third cycle");
        tick_div = 1;
        repeat (6) @(negedge clk);
        cfg_dbits = 2'd3; cfg_par = 2'd0;
    endtask

    task automatic t_break();
        int lows = 0;
        cmd(2);
        repeat (4) @(negedge clk);
        chk(txd === 1'b0, "R8", "break drives space", int'(txd), 0);
        chk(tx_rdy === 1'b1, "R8", "tx_rdy during break", int'(tx_rdy), 1);
        write_byte(8'h55);
        repeat (60) @(negedge clk);
        chk(txd === 1'b0, "R8", "break persists", int'(txd), 0);
        cmd(3);
        repeat (3) @(negedge clk);
        chk(txd === 1'b1, "R8", "mark after break stop", int'(txd), 1);
        for (int i = 0; i < 300; i++) begin
            if (txd !== 1'b1) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R8", "char written in break not sent", lows, 0);
        chk(tx_empty === 1'b1, "R8", "empty after break", int'(tx_empty), 1);
    endtask

    task automatic t_cts();
        int lows = 0;
        cfg_cts_gate = 1'b1; cts_n = 1'b1;
        exp_len = 0;
        push_frame(8'h3C);
        push(1'b1, 8);
        write_byte(8'h3C);
        for (int i = 0; i < 120; i++) begin
            if (txd !== 1'b1) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R9", "held while cts_n high", lows, 0);
        chk(tx_rdy === 1'b0, "R9", "char still held", int'(tx_rdy), 0);
        fork
            capture("R9", "frame after cts_n low");
            begin
                @(negedge clk);
                cts_n = 1'b0;
            end
        join
        cfg_cts_gate = 1'b0; cts_n = 1'b1;
    endtask

    task automatic t_rts();
        cfg_rts_auto = 1'b0;
        cmd(4);
        chk(rts_n === 1'b0, "R10", "rts_n after set", int'(rts_n), 0);
        send_one(8'h12, "R10", "frame without auto release");
        chk(rts_n === 1'b0, "R10", "rts_n kept without auto", int'(rts_n), 0);
        cfg_rts_auto = 1'b1;
        exp_len = 0;
        push_frame(8'hE7);
        push(1'b1, 8);
        fork
            capture("R10", "frame with auto release");
            begin
                write_byte(8'hE7);
                repeat (80) @(negedge clk);
                chk(rts_n === 1'b0, "R10", "rts_n held mid-frame", int'(rts_n), 0);
            end
        join
        chk(rts_n === 1'b1, "R10", "rts_n released after frame", int'(rts_n), 1);
        cfg_rts_auto = 1'b0;
    endtask

    task automatic t_disable_mid();
        exp_len = 0;
        push_frame(8'h5B);
        push(1'b1, 8);
        fork
            capture("R11", "frame completes after disable");
            begin
                write_byte(8'h5B);
                repeat (40) @(negedge clk);
                @(negedge clk);
                cmd_enable = 1'b1; cmd_disable = 1'b1;
                @(negedge clk);
                cmd_enable = 1'b0; cmd_disable = 1'b0;
            end
        join
        chk(tx_rdy === 1'b0 && tx_empty === 1'b0, "R11", "disabled flags",
            int'({tx_rdy, tx_empty}), 0);
    endtask

    initial begin
        #(8 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled_write();
        t_basic();
        t_formats();
        t_stop();
        t_x1();
        t_tickdiv();
        t_break();
        t_cts();
        t_rts();
        t_disable_mid();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule